// File: doc/BRIEF.md
# Software-Triggered DMA Burst Request Generator

This block sits on an 8-bit expansion card and produces the card's DMA request line. The device behind the card is never asked for its own request signal. Instead, software raises the request by writing to one dedicated I/O port. The host DMA controller runs in demand mode and then moves one byte per bus cycle, pairing an I/O read with a memory write or an I/O write with a memory read. The block counts these acknowledged transfers. After a fixed burst length it withdraws the request, so the host takes the bus back in time to refresh memory. Refresh must happen about every 15 µs, which is 72 bus clocks. At four clocks per byte, no more than 18 bytes fit in that window, and the default burst of 16 leaves a margin. Software moves a 512-byte sector as 32 such bursts, one port write per burst.

During an acknowledged cycle the address bus holds a memory address, not an I/O address. The block therefore also decodes the card's disk register window. While the acknowledge is active it forces selection of the disk data register. The request pin is always driven high or low while the DMA function is enabled, because the bus line has no pull-up. While the function is disabled, its output enable is off. All bus inputs are taken as synchronous to `clk`, which is the bus clock. Each event takes effect at the first clock edge after its strobe is released.

Top module: `swdma_burst_gen`

## Requirements
- R1: After reset, `drq_o` is 0 and the burst is idle. `drq_oe` equals `dma_en` from the first cycle onward.
- R2: With `dma_en` high and no burst active, an I/O write (`iow_n` low) to address `PORT_ADDR` (default 10'h318) raises `drq_o` when the write strobe ends. The write must have `aen` low and `dack_n` high.
- R3: An I/O write to any other address does not raise `drq_o`. Neither does a write to `PORT_ADDR` with `aen` high, nor an I/O read of `PORT_ADDR`.
- R4: Once raised, `drq_o` stays high through `BURST_LEN`-1 acknowledged transfers (default 16). It drops when the strobe of transfer number `BURST_LEN` ends.
- R5: A transfer counts only when an `ior_n` or `iow_n` strobe ends while `dack_n` is low and a burst is active. Strobes with `dack_n` high do not count. Acknowledged strobes while `drq_o` is low do not shorten the next burst.
- R6: A port write that arrives while a burst is in progress is ignored. It neither restarts nor extends the count.
- R7: Each newly raised burst counts from zero, so it always lasts exactly `BURST_LEN` transfers.
- R8: With `dma_en` low, `drq_oe` is 0, `drq_o` is 0, and port writes are ignored. Dropping `dma_en` cancels a burst in progress, and it stays cancelled when `dma_en` returns.
- R9: While `dack_n` is low, `ide_cs_o` is 1 and `ide_reg_o` equals `DATA_IDX` (default 0), whatever the address bus carries.
- R10: While `dack_n` is high, `ide_cs_o` is 1 exactly when `aen` is low and `io_addr[9:4]` equals the upper bits of `IDE_BASE` (default 10'h300). In that case `ide_reg_o` is `io_addr[3:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W (10) | Bus address |
| iow_n | input | 1 | I/O write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| aen | input | 1 | Address enable; high during host DMA cycles |
| dack_n | input | 1 | DMA acknowledge for this channel, active low |
| dma_en | input | 1 | DMA function enable |
| drq_o | output | 1 | DMA request value |
| drq_oe | output | 1 | Output enable for the DMA request pin |
| ide_cs_o | output | 1 | Disk register window select |
| ide_reg_o | output | IDE_REG_W (4) | Disk register index |

## Verification
The bench builds the block with its defaults: a burst of 16, a 10-bit address, the trigger port at 10'h318 and the disk window at 10'h300. A 16-transfer burst is short enough that directed sequences can reach the exact drop point. These sequences cover the 15th and 16th transfers, a trigger arriving mid-burst, and a burst cancelled by the enable. A long random mix of port writes, acknowledged and unacknowledged strobes, and enable toggles also completes many full bursts. Random addresses across the whole 10-bit space, with `aen` and `dack_n` varied, exercise the decode at both edges of the disk window.

// File: rtl/swdma_pkg.sv
package swdma_pkg;

  // Single-cycle events derived from the bus strobes.
  typedef struct packed {
    logic port_wr_done;  // trigger-port write has just ended
    logic xfer_done;     // acknowledged transfer strobe has just ended
  } bus_ev_t;

endpackage

// File: rtl/swdma_rst_sync.sv
module swdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/swdma_bus_events.sv
module swdma_bus_events
  import swdma_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 10,
  parameter logic [ADDR_W-1:0]      PORT_ADDR = 10'h318
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iow_n,
  input  logic              ior_n,
  input  logic              aen,
  input  logic              dack_n,
  output bus_ev_t           ev_o
);

  logic iow_act, ior_act, dack_act, any_act;
  logic hit_d, hit_q;
  logic xfer_d, xfer_q;

  assign iow_act  = ~iow_n;
  assign ior_act  = ~ior_n;
  assign dack_act = ~dack_n;
  assign any_act  = iow_act | ior_act;

  // Next-state: remember a qualifying strobe while it is asserted.
  always_comb begin
    hit_d  = iow_act & (io_addr == PORT_ADDR) & ~aen & ~dack_act;
    xfer_d = any_act & dack_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      xfer_q <= xfer_d;
    end
  end

  // Events fire on the trailing edge of the strobe.
  assign ev_o.port_wr_done = hit_q & ~iow_act;
  assign ev_o.xfer_done    = xfer_q & ~any_act;

endmodule

// File: rtl/swdma_burst_ctr.sv
module swdma_burst_ctr
  import swdma_pkg::*;
#(
  parameter int unsigned BURST_LEN = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_i,
  input  bus_ev_t ev_i,
  output logic    drq_o
);

  localparam int unsigned     CNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic             drq_d, drq_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             upd;

  always_comb begin
    drq_d = drq_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      drq_d = 1'b0;
      cnt_d = '0;
    end else if (!drq_q) begin
      if (ev_i.port_wr_done) begin
        drq_d = 1'b1;
        cnt_d = '0;
      end
    end else if (ev_i.xfer_done) begin
      if (cnt_q == LAST) begin
        drq_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  assign upd = (drq_d != drq_q) | (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      drq_q <= drq_d;
      cnt_q <= cnt_d;
    end
  end

  assign drq_o = drq_q;

  // R2: the request rises only after a trigger-port write while enabled
  assert_raise_by_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq_q) |-> ($past(ev_i.port_wr_done) && $past(en_i)));

  // R4: the request falls only at the last transfer or on disable
  assert_drop_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq_q) |-> (($past(ev_i.xfer_done) && $past(cnt_q) == LAST) || !$past(en_i)));

  // R7: an idle channel always holds a cleared count
  assert_idle_count_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !drq_q |-> (cnt_q == '0));

  // R8: disabling cancels any pending request
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !drq_q);

endmodule

// File: rtl/swdma_ide_decode.sv
module swdma_ide_decode #(
  parameter int unsigned          ADDR_W    = 10,
  parameter int unsigned          IDE_REG_W = 4,
  parameter logic [ADDR_W-1:0]    IDE_BASE  = 10'h300,
  parameter logic [IDE_REG_W-1:0] DATA_IDX  = '0
) (
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 aen,
  input  logic                 dack_n,
  output logic                 cs_o,
  output logic [IDE_REG_W-1:0] reg_o
);

  localparam int unsigned HI_W = ADDR_W - IDE_REG_W;
  localparam logic [HI_W-1:0] BASE_HI = IDE_BASE[ADDR_W-1:IDE_REG_W];

  logic win_hit;

  always_comb begin
    win_hit = ~aen & (io_addr[ADDR_W-1:IDE_REG_W] == BASE_HI);
    if (!dack_n) begin
      cs_o  = 1'b1;
      reg_o = DATA_IDX;
    end else begin
      cs_o  = win_hit;
      reg_o = io_addr[IDE_REG_W-1:0];
    end
  end

endmodule

// File: rtl/swdma_burst_gen.sv
module swdma_burst_gen
  import swdma_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 10,
  parameter int unsigned          IDE_REG_W = 4,
  parameter int unsigned          BURST_LEN = 16,
  parameter logic [ADDR_W-1:0]    PORT_ADDR = 10'h318,
  parameter logic [ADDR_W-1:0]    IDE_BASE  = 10'h300,
  parameter logic [IDE_REG_W-1:0] DATA_IDX  = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 iow_n,
  input  logic                 ior_n,
  input  logic                 aen,
  input  logic                 dack_n,
  input  logic                 dma_en,
  output logic                 drq_o,
  output logic                 drq_oe,
  output logic                 ide_cs_o,
  output logic [IDE_REG_W-1:0] ide_reg_o
);

  logic    rst_sync_n;
  bus_ev_t ev;
  logic    drq_core;

  swdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swdma_bus_events #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_events (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .io_addr (io_addr),
    .iow_n   (iow_n),
    .ior_n   (ior_n),
    .aen     (aen),
    .dack_n  (dack_n),
    .ev_o    (ev)
  );

  swdma_burst_ctr #(
    .BURST_LEN (BURST_LEN)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (dma_en),
    .ev_i  (ev),
    .drq_o (drq_core)
  );

  swdma_ide_decode #(
    .ADDR_W    (ADDR_W),
    .IDE_REG_W (IDE_REG_W),
    .IDE_BASE  (IDE_BASE),
    .DATA_IDX  (DATA_IDX)
  ) u_dec (
    .io_addr (io_addr),
    .aen     (aen),
    .dack_n  (dack_n),
    .cs_o    (ide_cs_o),
    .reg_o   (ide_reg_o)
  );

  // No pull-up on the bus line: drive it whenever the function is on.
  assign drq_oe = dma_en;
  assign drq_o  = drq_core & dma_en;

  // R9: an acknowledged cycle always lands on the data register
  assert_dack_selects_data_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dack_n |-> (ide_cs_o && ide_reg_o == DATA_IDX));

  // R5: a transfer event never raises the request on its own
  assert_xfer_no_raise_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev.xfer_done && !ev.port_wr_done && !drq_core) |=> !drq_core);

endmodule

// File: tb/swdma_burst_gen_tb.sv
module swdma_burst_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BURST      = 16;
  localparam logic [9:0] PORT = 10'h318;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic       iow_n = 1'b1, ior_n = 1'b1, aen = 1'b0, dack_n = 1'b1, dma_en = 1'b0;
  logic       drq_o, drq_oe, ide_cs_o;
  logic [3:0] ide_reg_o;

  int n_chk = 0, n_bad = 0;
  bit drq_m = 1'b0;
  int cnt_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swdma_burst_gen u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iow_n(iow_n), .ior_n(ior_n),
    .aen(aen), .dack_n(dack_n), .dma_en(dma_en), .drq_o(drq_o), .drq_oe(drq_oe),
    .ide_cs_o(ide_cs_o), .ide_reg_o(ide_reg_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_cs(input logic [9:0] a, input bit av, input bit dk);
    return dk ? 1'b1 : (!av && a[9:4] == 6'h30);
  endfunction

  function automatic int exp_reg(input logic [9:0] a, input bit dk);
    return dk ? 0 : int'(a[3:0]);
  endfunction

  task automatic check_pins(input string req);
    check({req, " drq"}, int'(drq_o), int'(drq_m & dma_en));
    check({req, " oe"}, int'(drq_oe), int'(dma_en));
  endtask

  // One bus cycle; dk=1 means acknowledged transfer.
  task automatic bus_cycle(input logic [9:0] a, input bit wr, input bit av,
                           input bit dk, input string req);
    @(negedge clk);
    io_addr = a; aen = av; dack_n = !dk;
    if (wr) iow_n = 1'b0; else ior_n = 1'b0;
    @(negedge clk);
    check({req, " cs"}, int'(ide_cs_o), int'(exp_cs(a, av, dk)));
    check({req, " reg"}, int'(ide_reg_o), exp_reg(a, dk));
    @(negedge clk);
    iow_n = 1'b1; ior_n = 1'b1;
    @(negedge clk);
    dack_n = 1'b1; aen = 1'b0;
    if (dma_en) begin
      if (!drq_m) begin
        if (wr && !av && !dk && a == PORT) begin drq_m = 1'b1; cnt_m = 0; end
      end else if (dk) begin
        cnt_m++;
        if (cnt_m == BURST) begin drq_m = 1'b0; cnt_m = 0; end
      end
    end
    @(negedge clk);
    check_pins(req);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    dma_en = v;
    if (!v) begin drq_m = 1'b0; cnt_m = 0; end
    @(negedge clk);
    @(negedge clk);
    check_pins("R8 enable");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pins("R1 reset");
    set_en(1'b1);
    check_pins("R1 after enable");

    // R8: trigger ignored while disabled
    set_en(1'b0);
    bus_cycle(PORT, 1, 0, 0, "R8 write while off");
    set_en(1'b1);

    // R3: near-misses do not trigger
    bus_cycle(PORT, 1, 1, 0, "R3 aen high");
    bus_cycle(10'h319, 1, 0, 0, "R3 other addr");
    bus_cycle(PORT, 0, 0, 0, "R3 read of port");
    bus_cycle(PORT, 1, 1, 1, "R3 dma write to port addr");

    // R2 raise, R5 unacked strobes, R4/R6 limit with mid-burst trigger
    bus_cycle(PORT, 1, 0, 0, "R2 trigger");
    for (int i = 0; i < 3; i++) bus_cycle(10'h302, 0, 0, 0, "R5 unacked read");
    for (int i = 0; i < 5; i++) bus_cycle(10'h1A5, 0, 1, 1, "R4 xfer");
    bus_cycle(PORT, 1, 0, 0, "R6 mid-burst trigger");
    for (int i = 0; i < 10; i++) bus_cycle(10'h0F0, 1, 1, 1, "R6 xfer");
    check("R4 high after 15", int'(drq_o), 1);
    bus_cycle(10'h0F1, 0, 1, 1, "R4 16th xfer");
    check("R4 low after 16", int'(drq_o), 0);

    // R5 acked strobes while idle, R7 fresh burst of full length
    bus_cycle(10'h3FF, 0, 1, 1, "R5 idle acked");
    bus_cycle(10'h3FE, 1, 1, 1, "R5 idle acked");
    bus_cycle(PORT, 1, 0, 0, "R7 new trigger");
    for (int i = 0; i < BURST - 1; i++) bus_cycle(10'h200, 0, 1, 1, "R7 xfer");
    check("R7 high after 15", int'(drq_o), 1);
    bus_cycle(10'h200, 0, 1, 1, "R7 last xfer");
    check("R7 low at end", int'(drq_o), 0);

    // R8 cancel mid-burst
    bus_cycle(PORT, 1, 0, 0, "R8 trigger");
    bus_cycle(10'h000, 0, 1, 1, "R8 xfer");
    set_en(1'b0);
    set_en(1'b1);
    check("R8 stays cancelled", int'(drq_o), 0);

    // R9/R10 decode corners
    bus_cycle(10'h300, 0, 0, 0, "R10 window low edge");
    bus_cycle(10'h30F, 0, 0, 0, "R10 window high edge");
    bus_cycle(10'h2FF, 0, 0, 0, "R10 below window");
    bus_cycle(10'h30A, 0, 1, 0, "R10 aen in window");
    bus_cycle(10'h30A, 0, 1, 1, "R9 dack in window");

    // Constrained random mix
    for (int i = 0; i < 700; i++) begin
      int op;
      logic [9:0] a;
      op = $urandom_range(99);
      a = 10'($urandom);
      if (op < 14)       bus_cycle(PORT, 1, 0, 0, "R2 rand trigger");
      else if (op < 70)  bus_cycle(a, op[0], 1, 1, "R4 rand xfer");
      else if (op < 85)  bus_cycle(a, op[0], 0, 0, "R10 rand io");
      else if (op < 95)  bus_cycle({6'h30, a[3:0]}, op[0], op[1], 0, "R10 rand window");
      else if (op < 98)  bus_cycle(PORT, op[0], 1, 0, "R3 rand aen");
      else               set_en(op[0]);
    end
    set_en(1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule